// File: doc/BRIEF.md
# Microcontroller R/D I/O Port Unit

This block holds the output latches and the read-back merge logic for the general-purpose I/O of a small 4-bit microcontroller core. It provides eleven nibble ports, indexed 0 to 10, and sixteen single-bit discrete lines. The last nibble port is only 2 bits wide. Each port and each line has a fixed pin type. A standard pin reads back the sampled pin value ANDed with its latch. A high-voltage pin reads back the sampled pin value ORed with its latch.

On the core side, the block takes a nibble load strobe and a nibble read strobe, which share a port index and a write nibble. It also takes set, clear and test strobes for the discrete lines, with a line index. On the pin side, it drives the latch contents out and registers the pin inputs once before they are merged. Some port indices are output-only, so a read of them is invalid. Some are input-only, so a load to them is dropped.

Top module: `mcu_io_ports`

## Requirements
- R1: After reset, nibble latches 3 to 9 hold 4'hF and latches 0, 1, 2 and 10 hold 0. The discrete latch is 16'h000F, so lines 0 to 3 are 1 and lines 4 to 15 are 0. The error and status outputs are 0.
- R2: A load strobe with an index from 0 to 8 writes the data nibble into that port's latch at the next clock edge. The latch appears on r_pin_o bits [4*idx+3:4*idx]. A load with an index of 9 or above leaves r_pin_o unchanged.
- R3: A read of a standard port (3, 4, 5, 9) returns the sampled pin nibble AND the latch. A read of a high-voltage port (1, 2, 10) returns the sampled pin nibble OR the latch. The result appears combinationally on r_rdata_o.
- R4: A read of port 10 returns only 2 bits, with r_rdata_o[3:2] = 0. Reads of all other ports return 4 bits.
- R5: A read of port 0, 6, 7, 8 or of any index above 10 returns 4'hF. It also raises r_err_o for exactly the one cycle after the read strobe. Valid reads never raise r_err_o.
- R6: A set or clear strobe changes only the indexed bit of the discrete latch, at the next clock edge. When both strobes are given, set wins. When neither is given, the latch holds.
- R7: d_wmask_o is the one-hot mask of d_idx_i while a set or clear strobe is high, and 0 otherwise.
- R8: A test strobe loads d_st_o at the next edge with the indexed bit of the merged discrete value. Lines 0 to 3 use the AND merge and lines 4 to 15 use the OR merge.
- R9: Pin inputs pass through one register before any merge. A read reflects the pin value that was present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| r_wr_i | input | 1 | Nibble port load strobe |
| r_rd_i | input | 1 | Nibble port read strobe |
| r_idx_i | input | 4 | Nibble port index |
| r_wdata_i | input | 4 | Nibble to load |
| r_rdata_o | output | 4 | Merged read-back nibble |
| r_err_o | output | 1 | Invalid read pulse, one cycle after the read |
| r_pin_i | input | 44 | Nibble port pin inputs, port i at bits [4i+3:4i] |
| r_pin_o | output | 44 | Nibble port latch outputs, port i at bits [4i+3:4i] |
| d_set_i | input | 1 | Discrete line set strobe |
| d_clr_i | input | 1 | Discrete line clear strobe |
| d_tst_i | input | 1 | Discrete line test strobe |
| d_idx_i | input | 4 | Discrete line index |
| d_pin_i | input | 16 | Discrete pin inputs |
| d_pin_o | output | 16 | Discrete latch outputs |
| d_wmask_o | output | 16 | One-hot pin write qualifier |
| d_st_o | output | 1 | Test result status flag |

## Verification
Read data is combinational, but it depends on pins registered one edge earlier. The bench therefore applies the pin value together with the read strobe and samples r_rdata_o at the following falling edge. At that same falling edge it also samples r_err_o, which is registered from that strobe, and then one more cycle later it confirms that the pulse has dropped. Latch loads and discrete set and clear are due one edge after the strobe, so they are checked at the next falling edge. d_wmask_o is combinational and is checked shortly after the strobe is driven, inside the same cycle. d_st_o is due one edge after its test strobe, and the pin change it depends on is applied a full cycle ahead of that strobe.

// File: rtl/mcu_io_pkg.sv
package mcu_io_pkg;
  localparam int unsigned NIB_W = 4;

  // and_mode: standard pin (AND merge); else high-voltage pin (OR merge)
  function automatic logic [NIB_W-1:0] merge_nib(input logic and_mode,
                                                 input logic [NIB_W-1:0] pin,
                                                 input logic [NIB_W-1:0] lat);
    return and_mode ? (pin & lat) : (pin | lat);
  endfunction
endpackage

// File: rtl/mcu_io_pin_sample.sv
module mcu_io_pin_sample #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/mcu_io_r_bank.sv
module mcu_io_r_bank
  import mcu_io_pkg::*;
#(
  parameter int unsigned   NUM_R      = 11,
  parameter int unsigned   IDX_W      = 4,
  parameter int unsigned   LAST_W     = 2,
  parameter int unsigned   MAX_WR     = 8,
  parameter logic [NUM_R-1:0] HV_MASK = 11'h407,
  parameter logic [NUM_R-1:0] WO_MASK = 11'h1C1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [NIB_W-1:0]       wdata_i,
  input  logic [NUM_R*NIB_W-1:0] pin_i,
  output logic [NUM_R*NIB_W-1:0] latch_o,
  output logic [NIB_W-1:0]       rdata_o,
  output logic                   err_o
);
  logic [NIB_W-1:0] lat [NUM_R];
  logic [NIB_W-1:0] rd_val [NUM_R];

  for (genvar i = 0; i < NUM_R; i++) begin : g_port
    localparam logic [NIB_W-1:0] WMSK =
      (i == NUM_R - 1) ? NIB_W'((1 << LAST_W) - 1) : {NIB_W{1'b1}};
    localparam logic [NIB_W-1:0] RST = HV_MASK[i] ? '0 : WMSK;
    localparam logic AND_MODE = (RST != '0);

    if (i <= MAX_WR) begin : g_wr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lat[i] <= RST;
        else if (wr_i && idx_i == IDX_W'(i)) lat[i] <= wdata_i & WMSK;
      end
    end else begin : g_ro
      assign lat[i] = RST;
    end

    assign rd_val[i]             = merge_nib(AND_MODE, pin_i[i*NIB_W +: NIB_W], lat[i]) & WMSK;
    assign latch_o[i*NIB_W +: NIB_W] = lat[i];
  end

  logic bad_idx;
  always_comb begin
    bad_idx = 1'b1;
    rdata_o = {NIB_W{1'b1}};
    for (int i = 0; i < NUM_R; i++) begin
      if (idx_i == IDX_W'(i) && !WO_MASK[i]) begin
        bad_idx = 1'b0;
        rdata_o = rd_val[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= rd_i && bad_idx;
  end
endmodule

// File: rtl/mcu_io_d_bank.sv
module mcu_io_d_bank #(
  parameter int unsigned        NUM_D   = 16,
  parameter int unsigned        IDX_W   = 4,
  parameter logic [NUM_D-1:0]   HV_MASK = 16'hFFF0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             tst_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [NUM_D-1:0] pin_i,
  output logic [NUM_D-1:0] latch_o,
  output logic [NUM_D-1:0] wmask_o,
  output logic             st_o
);
  logic [NUM_D-1:0] bit_sel;
  logic [NUM_D-1:0] merged;

  assign bit_sel = NUM_D'(1) << idx_i;
  assign wmask_o = (set_i || clr_i) ? bit_sel : '0;
  // standard lines AND-merge, high-voltage lines OR-merge
  assign merged  = (pin_i & latch_o & ~HV_MASK) | ((pin_i | latch_o) & HV_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    latch_o <= ~HV_MASK;
    else if (set_i) latch_o <= latch_o | bit_sel;
    else if (clr_i) latch_o <= latch_o & ~bit_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_o <= 1'b0;
    else if (tst_i) st_o <= |(merged & bit_sel);
  end
endmodule

// File: rtl/mcu_io_ports.sv
module mcu_io_ports #(
  parameter int unsigned       NUM_R     = 11,
  parameter int unsigned       NUM_D     = 16,
  parameter int unsigned       R_IDX_W   = 4,
  parameter int unsigned       LAST_W    = 2,
  parameter int unsigned       MAX_WR    = 8,
  parameter logic [NUM_R-1:0]  R_HV_MASK = 11'h407,
  parameter logic [NUM_R-1:0]  R_WO_MASK = 11'h1C1,
  parameter logic [NUM_D-1:0]  D_HV_MASK = 16'hFFF0,
  localparam int unsigned      D_IDX_W   = $clog2(NUM_D),
  localparam int unsigned      R_BUS_W   = NUM_R * 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               r_wr_i,
  input  logic               r_rd_i,
  input  logic [R_IDX_W-1:0] r_idx_i,
  input  logic [3:0]         r_wdata_i,
  output logic [3:0]         r_rdata_o,
  output logic               r_err_o,
  input  logic [R_BUS_W-1:0] r_pin_i,
  output logic [R_BUS_W-1:0] r_pin_o,
  input  logic               d_set_i,
  input  logic               d_clr_i,
  input  logic               d_tst_i,
  input  logic [D_IDX_W-1:0] d_idx_i,
  input  logic [NUM_D-1:0]   d_pin_i,
  output logic [NUM_D-1:0]   d_pin_o,
  output logic [NUM_D-1:0]   d_wmask_o,
  output logic               d_st_o
);
  logic [R_BUS_W-1:0] r_pin_q;
  logic [NUM_D-1:0]   d_pin_q;

  mcu_io_pin_sample #(.W(R_BUS_W)) u_r_smp (
    .clk_i, .rst_ni, .d_i(r_pin_i), .q_o(r_pin_q)
  );

  mcu_io_pin_sample #(.W(NUM_D)) u_d_smp (
    .clk_i, .rst_ni, .d_i(d_pin_i), .q_o(d_pin_q)
  );

  mcu_io_r_bank #(
    .NUM_R(NUM_R), .IDX_W(R_IDX_W), .LAST_W(LAST_W), .MAX_WR(MAX_WR),
    .HV_MASK(R_HV_MASK), .WO_MASK(R_WO_MASK)
  ) u_r_bank (
    .clk_i, .rst_ni,
    .wr_i(r_wr_i), .rd_i(r_rd_i), .idx_i(r_idx_i), .wdata_i(r_wdata_i),
    .pin_i(r_pin_q), .latch_o(r_pin_o), .rdata_o(r_rdata_o), .err_o(r_err_o)
  );

  mcu_io_d_bank #(
    .NUM_D(NUM_D), .IDX_W(D_IDX_W), .HV_MASK(D_HV_MASK)
  ) u_d_bank (
    .clk_i, .rst_ni,
    .set_i(d_set_i), .clr_i(d_clr_i), .tst_i(d_tst_i), .idx_i(d_idx_i),
    .pin_i(d_pin_q), .latch_o(d_pin_o), .wmask_o(d_wmask_o), .st_o(d_st_o)
  );
endmodule

// File: rtl/mcu_io_ports_chk.sv
module mcu_io_ports_chk #(
  parameter int unsigned      NUM_R     = 11,
  parameter int unsigned      NUM_D     = 16,
  parameter int unsigned      R_IDX_W   = 4,
  parameter int unsigned      MAX_WR    = 8,
  parameter logic [NUM_R-1:0] R_WO_MASK = 11'h1C1,
  localparam int unsigned     D_IDX_W   = $clog2(NUM_D),
  localparam int unsigned     R_BUS_W   = NUM_R * 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               r_wr_i,
  input logic               r_rd_i,
  input logic [R_IDX_W-1:0] r_idx_i,
  input logic [3:0]         r_rdata_o,
  input logic               r_err_o,
  input logic [R_BUS_W-1:0] r_pin_o,
  input logic               d_set_i,
  input logic               d_clr_i,
  input logic [D_IDX_W-1:0] d_idx_i,
  input logic [NUM_D-1:0]   d_pin_o,
  input logic [NUM_D-1:0]   d_wmask_o
);
  logic bad_rd;
  always_comb begin
    bad_rd = 1'b1;
    for (int i = 0; i < NUM_R; i++)
      if (r_idx_i == R_IDX_W'(i) && !R_WO_MASK[i]) bad_rd = 1'b0;
  end

  p_ignored_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_wr_i && r_idx_i > R_IDX_W'(MAX_WR)) |=> $stable(r_pin_o));

  p_last_port_w_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_idx_i == R_IDX_W'(NUM_R - 1)) |-> (r_rdata_o[3:2] == 2'b00));

  p_bad_rd_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_rd_i && bad_rd) |-> (r_rdata_o == 4'hF));

  p_err_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_rd_i && bad_rd) |=> r_err_o);

  p_err_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_rd_i || !bad_rd) |=> !r_err_o);

  p_d_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_set_i |=> (d_pin_o == ($past(d_pin_o) | (NUM_D'(1) << $past(d_idx_i)))));

  p_d_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_clr_i && !d_set_i) |=> (d_pin_o == ($past(d_pin_o) & ~(NUM_D'(1) << $past(d_idx_i)))));

  p_d_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!d_set_i && !d_clr_i) |=> $stable(d_pin_o));

  p_wmask_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(d_wmask_o));

  p_wmask_active_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_set_i || d_clr_i) |-> ($countones(d_wmask_o) == 1));
endmodule

bind mcu_io_ports mcu_io_ports_chk #(
  .NUM_R(NUM_R), .NUM_D(NUM_D), .R_IDX_W(R_IDX_W), .MAX_WR(MAX_WR), .R_WO_MASK(R_WO_MASK)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .r_wr_i(r_wr_i), .r_rd_i(r_rd_i), .r_idx_i(r_idx_i),
  .r_rdata_o(r_rdata_o), .r_err_o(r_err_o), .r_pin_o(r_pin_o),
  .d_set_i(d_set_i), .d_clr_i(d_clr_i), .d_idx_i(d_idx_i),
  .d_pin_o(d_pin_o), .d_wmask_o(d_wmask_o)
);

// File: tb/mcu_io_ports_tb_top.sv
module mcu_io_ports_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        r_wr = 1'b0, r_rd = 1'b0;
  logic [3:0]  r_idx = '0, r_wdata = '0;
  logic [3:0]  r_rdata;
  logic        r_err;
  logic [43:0] r_pin_in = '0;
  logic [43:0] r_pin_out;
  logic        d_set = 1'b0, d_clr = 1'b0, d_tst = 1'b0;
  logic [3:0]  d_idx = '0;
  logic [15:0] d_pin_in = '0;
  logic [15:0] d_pin_out, d_wmask;
  logic        d_st;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mcu_io_ports dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .r_wr_i(r_wr), .r_rd_i(r_rd), .r_idx_i(r_idx), .r_wdata_i(r_wdata),
    .r_rdata_o(r_rdata), .r_err_o(r_err), .r_pin_i(r_pin_in), .r_pin_o(r_pin_out),
    .d_set_i(d_set), .d_clr_i(d_clr), .d_tst_i(d_tst), .d_idx_i(d_idx),
    .d_pin_i(d_pin_in), .d_pin_o(d_pin_out), .d_wmask_o(d_wmask), .d_st_o(d_st)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {op(1=read), idx, wdata, pin nibble, expected, expected err}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 4'd3,  4'h5, 4'h0, 4'h5, 1'b0},  // R2 load
    {1'b1, 4'd3,  4'h0, 4'hF, 4'h5, 1'b0},  // R3 AND
    {1'b1, 4'd3,  4'h0, 4'hA, 4'h0, 1'b0},  // R3 AND
    {1'b0, 4'd1,  4'h9, 4'h0, 4'h9, 1'b0},  // R2 load
    {1'b1, 4'd1,  4'h0, 4'h2, 4'hB, 1'b0},  // R3 OR
    {1'b1, 4'd2,  4'h0, 4'h6, 4'h6, 1'b0},  // R3 OR
    {1'b1, 4'd10, 4'h0, 4'hF, 4'h3, 1'b0},  // R4 2-bit
    {1'b1, 4'd9,  4'h0, 4'hC, 4'hC, 1'b0},  // R3 AND
    {1'b1, 4'd0,  4'h0, 4'h7, 4'hF, 1'b1},  // R5
    {1'b1, 4'd7,  4'h0, 4'h0, 4'hF, 1'b1},  // R5
    {1'b1, 4'd12, 4'h0, 4'h0, 4'hF, 1'b1},  // R5
    {1'b0, 4'd9,  4'h0, 4'h0, 4'hF, 1'b0},  // R2 ignored
    {1'b0, 4'd10, 4'hF, 4'h0, 4'h0, 1'b0},  // R2 ignored
    {1'b0, 4'd8,  4'h3, 4'h0, 4'h3, 1'b0},  // R2 load
    {1'b1, 4'd8,  4'h0, 4'h0, 4'hF, 1'b1},  // R5
    {1'b0, 4'd6,  4'hC, 4'h0, 4'hC, 1'b0},  // R2 load
    {1'b1, 4'd9,  4'h0, 4'h3, 4'h3, 1'b0}   // R3 after ignored load
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [43:0] exp_rst;
    logic [43:0] snap;
    exp_rst = '0;
    for (int p = 3; p <= 9; p++) exp_rst[p*4 +: 4] = 4'hF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(r_pin_out == exp_rst, "R1 nibble latches", r_pin_out, exp_rst);
    check(d_pin_out == 16'h000F, "R1 discrete latch", d_pin_out, 16'h000F);
    check(!r_err && !d_st, "R1 err/status", {r_err, d_st}, 0);
    check(d_wmask == 16'h0, "R7 idle mask", d_wmask, 0);

    for (int k = 0; k < NV; k++) begin
      logic [17:0] v;
      int idx;
      v   = VEC[k];
      idx = int'(v[16:13]);
      if (v[17]) begin
        if (idx < 11) r_pin_in[idx*4 +: 4] = v[8:5];
        r_idx = v[16:13]; r_rd = 1'b1;
        @(negedge clk);
        check(r_rdata == v[4:1], $sformatf("R3/R4/R5 read idx %0d", idx), r_rdata, v[4:1]);
        check(r_err == v[0], $sformatf("R5 err idx %0d", idx), r_err, v[0]);
        r_rd = 1'b0;
      end else begin
        r_idx = v[16:13]; r_wdata = v[12:9]; r_wr = 1'b1;
        @(negedge clk);
        r_wr = 1'b0;
        check(r_pin_out[idx*4 +: 4] == v[4:1], $sformatf("R2 latch idx %0d", idx),
              r_pin_out[idx*4 +: 4], v[4:1]);
      end
    end

    // R5: pulse lasts one cycle only
    r_idx = 4'd6; r_rd = 1'b1;
    @(negedge clk);
    r_rd = 1'b0;
    check(r_err, "R5 pulse high", r_err, 1);
    @(negedge clk);
    check(!r_err, "R5 pulse one cycle", r_err, 0);

    // R2: out-of-range load leaves whole bus unchanged
    snap = r_pin_out;
    r_idx = 4'd13; r_wdata = 4'h0; r_wr = 1'b1;
    @(negedge clk);
    r_wr = 1'b0;
    check(r_pin_out == snap, "R2 idx 13 ignored", r_pin_out, snap);

    // R9: port 3 latch 5, pin A -> 0; pin F visible only after an edge
    r_idx = 4'd3;
    r_pin_in[12 +: 4] = 4'hF;
    #1;
    check(r_rdata == 4'h0, "R9 before edge", r_rdata, 0);
    @(negedge clk);
    check(r_rdata == 4'h5, "R9 after edge", r_rdata, 5);

    // R6/R7 discrete set and clear
    d_idx = 4'd9; d_set = 1'b1;
    #1;
    check(d_wmask == 16'h0200, "R7 set mask", d_wmask, 16'h0200);
    @(negedge clk);
    d_set = 1'b0;
    check(d_pin_out == 16'h020F, "R6 set line 9", d_pin_out, 16'h020F);
    d_idx = 4'd1; d_clr = 1'b1;
    #1;
    check(d_wmask == 16'h0002, "R7 clr mask", d_wmask, 16'h0002);
    @(negedge clk);
    d_clr = 1'b0;
    check(d_pin_out == 16'h020D, "R6 clr line 1", d_pin_out, 16'h020D);
    d_idx = 4'd5; d_set = 1'b1; d_clr = 1'b1;
    @(negedge clk);
    d_set = 1'b0; d_clr = 1'b0;
    check(d_pin_out == 16'h022D, "R6 set wins", d_pin_out, 16'h022D);
    #1;
    check(d_wmask == 16'h0, "R7 mask idle", d_wmask, 0);
    @(negedge clk);
    check(d_pin_out == 16'h022D, "R6 hold", d_pin_out, 16'h022D);

    // R8 discrete test
    d_idx = 4'd9; d_tst = 1'b1;
    @(negedge clk);
    check(d_st == 1'b1, "R8 OR line 9", d_st, 1);
    d_idx = 4'd4;
    @(negedge clk);
    check(d_st == 1'b0, "R8 OR line 4 low", d_st, 0);
    d_tst = 1'b0;
    d_pin_in[4] = 1'b1; d_pin_in[0] = 1'b0; d_pin_in[1] = 1'b1;
    @(negedge clk);
    d_tst = 1'b1;
    @(negedge clk);
    check(d_st == 1'b1, "R8 OR line 4 pin", d_st, 1);
    d_idx = 4'd0;
    @(negedge clk);
    check(d_st == 1'b0, "R8 AND line 0 pin low", d_st, 0);
    d_idx = 4'd1;
    @(negedge clk);
    check(d_st == 1'b0, "R8 AND line 1 latch low", d_st, 0);
    d_tst = 1'b0;
    d_pin_in[0] = 1'b1;
    @(negedge clk);
    d_idx = 4'd0; d_tst = 1'b1;
    @(negedge clk);
    d_tst = 1'b0;
    check(d_st == 1'b1, "R8 AND line 0 pin high", d_st, 1);
    @(negedge clk);
    check(d_st == 1'b1, "R8 status holds", d_st, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule